// File: doc/BRIEF.md
# Masked dual-rail nonlinear gate

This block computes a two-input nonlinear Boolean function F(a, b) on first-order masked operands. Each operand is split into two shares, a = a1 xor a2 and b = b1 xor b2. The second share arrives on a true rail and a complement rail. The result comes out as two shares, x1 and x2, with x2 also on a complement rail.

A mask-table layer works only on the first shares and a fresh random bit r. It sets x1 = r and builds an 8-bit table that a register holds. The operation layer combines the registered table with the registered second-share rails. It uses only AND and OR gates to drive the x2 rails, so every wire can only rise during evaluation.

The register stage alternates between a precharge phase, in which every operation-layer input is zero, and an evaluation phase. The stage never evaluates twice in a row, so every evaluation is preceded by a precharge. A parameter selects F.

Top module: `masked_dr_gate`

## Requirements
- R1: While rst_ni is low, and until the first evaluation, x1_o, x2_o and x2_n_o are 0.
- R2: After a clock edge at which pre_i is 1, the operation-layer inputs are all 0, and x2_o and x2_n_o are both 0.
- R3: After a clock edge at which the stage evaluates, x1_o equals the r_i sampled at that edge. x1_o holds its value through precharge cycles.
- R4: After an evaluating edge, x1_o xor x2_o equals F(a1_i xor a2_i, b1_i xor b2_i), using the operands sampled at that edge.
- R5: After an evaluating edge with complementary input rails, exactly one of x2_o and x2_n_o is 1.
- R6: The stage evaluates at an edge only if pre_i is 0 and the stage is currently precharged. If pre_i is 0 while the stage is evaluating, the stage precharges instead, and both x2 rails are 0 in the following cycle.
- R7: FUNC_SEL picks F. The value 0 gives AND, 1 gives OR, and 2 gives the truth table TRUTH_TBL, where bit index 2a+b holds F(a, b).
- R8: In evaluation the registered table holds exactly four ones. Table bit 4+2i+j is F(a1 xor j, b1 xor i) xor r, and table bit 2i+j is its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pre_i | input | 1 | Precharge request for the next cycle |
| a1_i | input | 1 | First share of operand a |
| b1_i | input | 1 | First share of operand b |
| r_i | input | 1 | Fresh random bit |
| a2_i | input | 1 | Second share of a, true rail |
| a2_n_i | input | 1 | Second share of a, complement rail |
| b2_i | input | 1 | Second share of b, true rail |
| b2_n_i | input | 1 | Second share of b, complement rail |
| x1_o | output | 1 | First output share |
| x2_o | output | 1 | Second output share, true rail |
| x2_n_o | output | 1 | Second output share, complement rail |

## Verification
The bench builds three copies of the gate side by side and drives them with the same stimulus:
- FUNC_SEL=0 (AND).
- FUNC_SEL=1 (OR).
- FUNC_SEL=2 with TRUTH_TBL=4'b0100, the asymmetric function a and not b.

The asymmetric function exposes any swap of the a and b table axes or of the rail selection, which AND and OR would hide. Each copy sees all 32 combinations of (a1, b1, a2, b2, r), each after a precharge. Runs of back-to-back evaluation requests exercise the forced precharge.

// File: rtl/mdg_pkg.sv
package mdg_pkg;
  typedef enum logic [1:0] {
    FUNC_AND = 2'd0,
    FUNC_OR  = 2'd1,
    FUNC_LUT = 2'd2
  } func_e;

  localparam int unsigned TBL_W = 8;

  // truth table, index {a,b}
  function automatic logic [3:0] tt_of(func_e sel, logic [3:0] custom);
    case (sel)
      FUNC_AND: return 4'b1000;
      FUNC_OR:  return 4'b1110;
      default:  return custom;
    endcase
  endfunction
endpackage

// File: rtl/mdg_mask_table.sv
module mdg_mask_table #(
  parameter logic [3:0] TT = 4'b1000
) (
  input  logic                     a1_i,
  input  logic                     b1_i,
  input  logic                     r_i,
  output logic [mdg_pkg::TBL_W-1:0] t_o
);
  for (genvar gi = 0; gi < 2; gi++) begin : g_i
    for (genvar gj = 0; gj < 2; gj++) begin : g_j
      localparam logic FI = 1'(gi);
      localparam logic FJ = 1'(gj);
      logic hit;
      assign hit = TT[{a1_i ^ FJ, b1_i ^ FI}] ^ r_i;
      assign t_o[4 + 2*gi + gj] = hit;
      assign t_o[2*gi + gj]     = ~hit;
    end
  end
endmodule

// File: rtl/mdg_stage.sv
module mdg_stage (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      pre_i,
  input  logic [mdg_pkg::TBL_W-1:0] t_i,
  input  logic                      r_i,
  input  logic                      a_t_i,
  input  logic                      a_f_i,
  input  logic                      b_t_i,
  input  logic                      b_f_i,
  output logic [mdg_pkg::TBL_W-1:0] t_o,
  output logic                      a_t_o,
  output logic                      a_f_o,
  output logic                      b_t_o,
  output logic                      b_f_o,
  output logic                      x1_o,
  output logic                      eval_o
);
  logic load;
  assign load = !pre_i && !eval_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eval_o <= 1'b0;
      t_o    <= '0;
      a_t_o  <= 1'b0;
      a_f_o  <= 1'b0;
      b_t_o  <= 1'b0;
      b_f_o  <= 1'b0;
      x1_o   <= 1'b0;
    end else if (load) begin
      eval_o <= 1'b1;
      t_o    <= t_i;
      a_t_o  <= a_t_i;
      a_f_o  <= a_f_i;
      b_t_o  <= b_t_i;
      b_f_o  <= b_f_i;
      x1_o   <= r_i;
    end else begin
      eval_o <= 1'b0;
      t_o    <= '0;
      a_t_o  <= 1'b0;
      a_f_o  <= 1'b0;
      b_t_o  <= 1'b0;
      b_f_o  <= 1'b0;
    end
  end

  // R6: no two evaluations back to back
  a_r6_alternate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_o |=> !eval_o);
  // R2: precharge drives every operation-layer input low
  a_r2_pre_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pre_i) |-> (t_o == '0 && !a_t_o && !a_f_o && !b_t_o && !b_f_o));
  // R8: evaluated table is balanced
  a_r8_table_weight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_o |-> $countones(t_o) == 4);
  // R3: x1 holds across precharge
  a_r3_x1_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |=> $stable(x1_o));
endmodule

// File: rtl/mdg_op_layer.sv
module mdg_op_layer (
  input  logic [mdg_pkg::TBL_W-1:0] t_i,
  input  logic                      a_t_i,
  input  logic                      a_f_i,
  input  logic                      b_t_i,
  input  logic                      b_f_i,
  output logic                      x2_o,
  output logic                      x2_n_o
);
  logic [mdg_pkg::TBL_W-1:0] s;

  for (genvar k = 0; k < mdg_pkg::TBL_W; k++) begin : g_term
    localparam int unsigned SJ = k % 2;
    localparam int unsigned SI = (k / 2) % 2;
    logic a_sel, b_sel;
    if (SJ == 1) begin : g_at
      assign a_sel = a_t_i;
    end else begin : g_af
      assign a_sel = a_f_i;
    end
    if (SI == 1) begin : g_bt
      assign b_sel = b_t_i;
    end else begin : g_bf
      assign b_sel = b_f_i;
    end
    assign s[k] = t_i[k] & a_sel & b_sel;
  end

  assign x2_o   = |s[7:4];
  assign x2_n_o = |s[3:0];
endmodule

// File: rtl/masked_dr_gate.sv
module masked_dr_gate #(
  parameter mdg_pkg::func_e FUNC_SEL  = mdg_pkg::FUNC_AND,
  parameter logic [3:0]     TRUTH_TBL = 4'b1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pre_i,
  input  logic a1_i,
  input  logic b1_i,
  input  logic r_i,
  input  logic a2_i,
  input  logic a2_n_i,
  input  logic b2_i,
  input  logic b2_n_i,
  output logic x1_o,
  output logic x2_o,
  output logic x2_n_o
);
  localparam logic [3:0] TT = mdg_pkg::tt_of(FUNC_SEL, TRUTH_TBL);

  logic [mdg_pkg::TBL_W-1:0] t_d, t_q;
  logic a_t_q, a_f_q, b_t_q, b_f_q, stage_eval;

  mdg_mask_table #(.TT(TT)) u_table (
    .a1_i (a1_i),
    .b1_i (b1_i),
    .r_i  (r_i),
    .t_o  (t_d)
  );

  mdg_stage u_stage (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pre_i  (pre_i),
    .t_i    (t_d),
    .r_i    (r_i),
    .a_t_i  (a2_i),
    .a_f_i  (a2_n_i),
    .b_t_i  (b2_i),
    .b_f_i  (b2_n_i),
    .t_o    (t_q),
    .a_t_o  (a_t_q),
    .a_f_o  (a_f_q),
    .b_t_o  (b_t_q),
    .b_f_o  (b_f_q),
    .x1_o   (x1_o),
    .eval_o (stage_eval)
  );

  mdg_op_layer u_op (
    .t_i    (t_q),
    .a_t_i  (a_t_q),
    .a_f_i  (a_f_q),
    .b_t_i  (b_t_q),
    .b_f_i  (b_f_q),
    .x2_o   (x2_o),
    .x2_n_o (x2_n_o)
  );

  // R2, R6: rails stay low outside evaluation
  a_r2_rails_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stage_eval |-> (!x2_o && !x2_n_o));
  // R5: complementary rails in, one-hot rails out
  a_r5_one_hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_eval && (a_t_q ^ a_f_q) && (b_t_q ^ b_f_q)) |-> (x2_o ^ x2_n_o));
  // R5: never both rails high
  a_r5_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({x2_o, x2_n_o}));
endmodule

// File: tb/masked_dr_gate_tb.sv
`timescale 1ns/1ps
module masked_dr_gate_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pre = 1'b1, a1 = 1'b0, b1 = 1'b0, r = 1'b0, a2 = 1'b0, b2 = 1'b0;
  logic [2:0] x1, x2, x2n;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // R7: encodings of the three copies, index {a,b}
  localparam logic [3:0] TT_REF [3] = '{4'b1000, 4'b1110, 4'b0100};

  masked_dr_gate #(.FUNC_SEL(mdg_pkg::FUNC_AND)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pre_i(pre), .a1_i(a1), .b1_i(b1), .r_i(r),
    .a2_i(a2), .a2_n_i(~a2), .b2_i(b2), .b2_n_i(~b2),
    .x1_o(x1[0]), .x2_o(x2[0]), .x2_n_o(x2n[0]));
  masked_dr_gate #(.FUNC_SEL(mdg_pkg::FUNC_OR)) u_dut_or (
    .clk_i(clk), .rst_ni(rst_n), .pre_i(pre), .a1_i(a1), .b1_i(b1), .r_i(r),
    .a2_i(a2), .a2_n_i(~a2), .b2_i(b2), .b2_n_i(~b2),
    .x1_o(x1[1]), .x2_o(x2[1]), .x2_n_o(x2n[1]));
  masked_dr_gate #(.FUNC_SEL(mdg_pkg::FUNC_LUT), .TRUTH_TBL(4'b0100)) u_dut_lut (
    .clk_i(clk), .rst_ni(rst_n), .pre_i(pre), .a1_i(a1), .b1_i(b1), .r_i(r),
    .a2_i(a2), .a2_n_i(~a2), .b2_i(b2), .b2_n_i(~b2),
    .x1_o(x1[2]), .x2_o(x2[2]), .x2_n_o(x2n[2]));

  // reference model (R6 phase rule)
  bit m_eval, m_x1, m_a, m_b;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_eval <= 1'b0; m_x1 <= 1'b0; m_a <= 1'b0; m_b <= 1'b0;
    end else if (pre || m_eval) begin
      m_eval <= 1'b0;
    end else begin
      m_eval <= 1'b1; m_x1 <= r; m_a <= a1 ^ a2; m_b <= b1 ^ b2;
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      for (int d = 0; d < 3; d++) begin
        logic f, ex2, ex2n;
        f = TT_REF[d][{m_a, m_b}];
        ex2  = m_eval ? (f ^ m_x1) : 1'b0;
        ex2n = m_eval ? ~(f ^ m_x1) : 1'b0;
        if (!rst_n) begin
          chk("R1", "x1", x1[d], 1'b0);
          chk("R1", "x2", x2[d], 1'b0);
          chk("R1", "x2_n", x2n[d], 1'b0);
        end else if (!m_eval) begin
          chk("R2/R6", "x2", x2[d], 1'b0);
          chk("R2/R6", "x2_n", x2n[d], 1'b0);
          chk("R3", "x1 held", x1[d], m_x1);
        end else begin
          chk("R3", "x1", x1[d], m_x1);
          chk("R4/R7/R8", "x1^x2", x1[d] ^ x2[d], f);
          chk("R5", "x2", x2[d], ex2);
          chk("R5", "x2_n", x2n[d], ex2n);
        end
      end
    end
  end

  task automatic step(logic p, logic [4:0] v);
    @(negedge clk);
    #1;
    pre = p;
    {a1, b1, a2, b2, r} = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R4, R7, R8: exhaustive after precharge
    for (int v = 0; v < 32; v++) begin
      step(1'b1, 5'(v));
      step(1'b0, 5'(v));
    end
    // R6: back-to-back evaluation requests
    for (int v = 0; v < 8; v++) step(1'b0, 5'(v * 5 + 3));
    // R2: held precharge
    repeat (3) step(1'b1, 5'b10101);
    step(1'b0, 5'b11011);
    step(1'b1, 5'b00000);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<5000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule